// File: doc/BRIEF.md
# Linear to mu-law compressor

This block turns one signed 16-bit linear sample into the 8-bit companded code that a telephone-band codec expects on its receive side. It reduces the sample to a sign and a 13-bit magnitude. It adds a fixed bias of 31 and finds the most significant one of the biased value. That position becomes a 3-bit segment number. The four bits just beneath it become the step. The sign, segment and step are then packed into a byte, and the whole byte is inverted before it leaves the block.

The block sits between a linear-domain processing stage and a serialiser. A producer presents a sample with a one-cycle strobe. The code appears on the next clock edge with its own strobe. Between strobes the last code stays on the output. Lower bits are discarded, so the block only truncates and never rounds. Any serial transfer is left to the stage that follows.

Top module: `mulaw_compress`

## Requirements
- R1: The sign comes from bit 15 of the input. A zero or positive sample puts a 1 in output bit 7, and a negative sample puts a 0 there. That bit is the inverse of the sign flag.
- R2: The 13-bit magnitude is the two's-complement absolute value of the input with its two lowest bits dropped. The single case that would reach 8192 (input -32768) is clamped to 8191.
- R3: The bias of 31 is added to the 13-bit magnitude before the leading-one search. So magnitude 1 (input 4) lands in segment 0, step 0, with a code that differs from input 0 only through that bias.
- R4: When the leading one of the biased value sits at bit position p, for p from 5 to 12, the segment is p-5. Output bits 6..4 carry the inverted segment.
- R5: The step is the four biased bits directly below the leading one, at positions p-1 down to p-4. Output bits 3..0 carry the inverted step. Every lower bit is dropped.
- R6: A biased value below 32, which only magnitude 0 produces, gives segment 0, step 0. Input 0 therefore gives output 8'hFF.
- R7: A biased value of 8192 or more, from a magnitude of 8161 or more, saturates to segment 7, step 15. Output bits 6..0 are then all zero.
- R8: The output byte is the bitwise complement of {sign, segment, step}.
- R9: The output is registered with one cycle of latency. out_valid is in_valid delayed by one clock.
- R10: While in_valid is low, out_code keeps its last value, whatever in_sample carries.
- R11: A synchronous active-low reset clears out_valid to 0 and sets out_code to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe marking in_sample as a new sample |
| in_sample | input | 16 | Signed two's-complement linear sample |
| out_valid | output | 1 | Strobe, one cycle after in_valid |
| out_code | output | 8 | Inverted mu-law code, held between strobes |

## Verification
Each output is a pure function of one sample, so any internal fault shows up in the code registered on the very next edge. A wrong priority choice shows as a wrong pattern in bits 6..4 at a segment boundary. A mis-sliced step shows as wrong bits 3..0 one position off the leading one. A bad bias or clamp shows only near zero or near full scale, which is why the stimulus targets both sides of every power-of-two boundary and both extremes. A fault in the hold or strobe path shows within one cycle of the first gap in in_valid.

// File: rtl/mulaw_pkg.sv
// Package: shared constants and the packed code layout for the mu-law compressor.
// Assumes eight segments of four-bit steps; the widths below follow from that.
package mulaw_pkg;
    localparam int SEG_COUNT = 8;
    localparam int SEG_W     = $clog2(SEG_COUNT);
    localparam int STEP_W    = 4;
    localparam int CODE_W    = 1 + SEG_W + STEP_W;

    typedef struct packed {
        logic              sign;
        logic [SEG_W-1:0]  seg;
        logic [STEP_W-1:0] step;
    } mu_code_t;
endpackage

// File: rtl/mulaw_mag.sv
// Module: mulaw_mag
// Splits a signed sample into a sign and a biased magnitude.
// The magnitude is scaled to MAG_W bits and clamped. The bias is then added.
// Assumes IN_W > MAG_W. The flag ovf marks a biased value that no longer fits in MAG_W bits.
module mulaw_mag #(
    parameter int IN_W  = 16,
    parameter int MAG_W = 13,
    parameter int BIAS  = 31
) (
    input  logic [IN_W-1:0]  sample,
    output logic             sign,
    output logic [MAG_W-1:0] biased,
    output logic             ovf
);
    localparam int DROP  = IN_W - 1 - MAG_W;
    localparam int SCL_W = IN_W - DROP;
    localparam int SUM_W = MAG_W + 1;
    localparam logic [SCL_W-1:0] MAX_MAG = SCL_W'((1 << MAG_W) - 1);
    localparam logic [SUM_W-1:0] BIAS_V  = SUM_W'(BIAS);

    logic [IN_W-1:0]  abs_full;
    logic [SCL_W-1:0] scaled;
    logic [MAG_W-1:0] mag;
    logic [SUM_W-1:0] sum;

    // Absolute value, scaling, clamp and bias addition.
    always_comb begin
        sign     = sample[IN_W-1];
        abs_full = sign ? (~sample + 1'b1) : sample;
        scaled   = abs_full[IN_W-1:DROP];
        mag      = (scaled > MAX_MAG) ? MAX_MAG[MAG_W-1:0] : scaled[MAG_W-1:0];
        sum      = {1'b0, mag} + BIAS_V;
        biased   = sum[MAG_W-1:0];
        ovf      = sum[MAG_W];
    end
endmodule

// File: rtl/mulaw_seg.sv
// Module: mulaw_seg
// Priority encoder for the biased magnitude.
// It finds the leading one among the top SEG_COUNT bit positions and returns its segment index.
// The step is the STEP_W bits just below that one.
// Assumes MAG_W - SEG_COUNT >= STEP_W. Below the lowest position it gives segment 0, step 0.
// When ovf is set it gives the largest segment and the largest step.
module mulaw_seg
    import mulaw_pkg::*;
#(
    parameter int MAG_W = 13
) (
    input  logic [MAG_W-1:0]  biased,
    input  logic              ovf,
    output logic [SEG_W-1:0]  seg,
    output logic [STEP_W-1:0] step,
    output logic [SEG_COUNT-1:0] lead
);
    localparam int LOW_POS = MAG_W - SEG_COUNT;

    logic [STEP_W-1:0] slice [SEG_COUNT];
    logic [SEG_W-1:0]  enc_seg;
    logic [STEP_W-1:0] enc_step;

    // One candidate per segment: that bit is set and every bit above it is clear.
    for (genvar i = 0; i < SEG_COUNT; i++) begin : g_cand
        if (i == SEG_COUNT - 1) begin : g_top
            assign lead[i] = biased[LOW_POS + i];
        end else begin : g_low
            assign lead[i] = biased[LOW_POS + i] & ~(|biased[MAG_W-1:LOW_POS+i+1]);
        end
        assign slice[i] = biased[LOW_POS + i - 1 -: STEP_W];
    end

    // Merge the one-hot candidates into a segment index and its step.
    always_comb begin
        enc_seg  = '0;
        enc_step = '0;
        for (int i = 0; i < SEG_COUNT; i++) begin
            if (lead[i]) begin
                enc_seg  = enc_seg | SEG_W'(i);
                enc_step = enc_step | slice[i];
            end
        end
    end

    // Saturation takes priority over the encoder result.
    always_comb begin
        if (ovf) begin
            seg  = '1;
            step = '1;
        end else begin
            seg  = enc_seg;
            step = enc_step;
        end
    end

    // At most one candidate may claim the leading position (R4).
    always_comb begin
        if (!$isunknown(biased)) begin
            p_one_lead_r4: assert ($onehot0(lead));
        end
    end
endmodule

// File: rtl/mulaw_compress.sv
// Module: mulaw_compress (top)
// Registered linear-to-mu-law compressor.
// It packs sign, segment and step, inverts the byte and registers it one cycle after in_valid.
// The code holds between strobes. Reset is synchronous and active low.
module mulaw_compress
    import mulaw_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int MAG_W = 13,
    parameter int BIAS  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_sample,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code
);
    logic              sign;
    logic [MAG_W-1:0]  biased;
    logic              ovf;
    logic [SEG_W-1:0]  seg;
    logic [STEP_W-1:0] step;
    logic [SEG_COUNT-1:0] lead;
    mu_code_t          code;

    mulaw_mag #(.IN_W(IN_W), .MAG_W(MAG_W), .BIAS(BIAS)) mag_i (
        .sample (in_sample),
        .sign   (sign),
        .biased (biased),
        .ovf    (ovf)
    );

    mulaw_seg #(.MAG_W(MAG_W)) seg_i (
        .biased (biased),
        .ovf    (ovf),
        .seg    (seg),
        .step   (step),
        .lead   (lead)
    );

    // Pack the fields of the uninverted code.
    always_comb begin
        code.sign = sign;
        code.seg  = seg;
        code.step = step;
    end

    // Output register: strobe follows the input, and the code loads only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '1;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_code <= ~code;
            end
        end
    end

    // R9: the output strobe is the input strobe one cycle later.
    p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10: no strobe, no change of code.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_code));
    // R1: output bit 7 is the inverted input sign.
    p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_code[CODE_W-1] == !$past(in_sample[IN_W-1])));
    // R6: a zero sample gives the all-ones code.
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sample == '0) |=> (out_code == '1));
    // R7: saturation clears the inverted segment and step bits.
    p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovf) |=> (out_code[CODE_W-2:0] == '0));
endmodule

// File: tb/mulaw_compress_tb.sv
// Bench: drives samples on the falling edge, and keeps a behavioural model
// updated on the rising edge, then compares the outputs on every falling edge.
module mulaw_compress_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [7:0]  out_code;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R8";

    logic  exp_valid = 1'b0;
    logic [7:0] exp_code = 8'hFF;
    string exp_tag = "R11";
    bit    model_live = 1'b0;

    always #5 clk = ~clk;

    mulaw_compress dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    // Behavioural reference from the requirements, using integer arithmetic.
    function automatic logic [7:0] ref_code(input logic [15:0] raw);
        int v, m, b, seg, step;
        bit s, found;
        v = int'($signed(raw));
        s = (v < 0);
        m = s ? -v : v;
        m = m / 4;
        if (m > 8191) m = 8191;
        b = m + 31;
        seg = 0; step = 0; found = 0;
        if (b >= 8192) begin
            seg = 7; step = 15;
        end else if (b >= 32) begin
            for (int p = 12; p >= 5; p--) begin
                if (!found && ((b >> p) & 1) == 1) begin
                    found = 1;
                    seg = p - 5;
                    step = (b >> (p - 4)) & 15;
                end
            end
        end
        return ~{s, 3'(seg), 4'(step)};
    endfunction

    // Model update on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_code  <= 8'hFF;
            exp_tag   <= "R11";
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                exp_code <= ref_code(in_sample);
                exp_tag  <= cur_tag;
            end else begin
                exp_tag  <= "R10";
            end
        end
        model_live <= 1'b1;
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (model_live && !done) begin
            checks++;
            if (out_valid !== exp_valid) begin
                errors++;
                $display("FAIL R9 out_valid actual=%b expected=%b", out_valid, exp_valid);
            end
            checks++;
            if (out_code !== exp_code) begin
                errors++;
                $display("FAIL %s out_code actual=%h expected=%h", exp_tag, out_code, exp_code);
            end
        end
    end

    task automatic send(input logic [15:0] x, input string tag);
        @(negedge clk);
        cur_tag   = tag;
        in_valid  = 1'b1;
        in_sample = x;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = 16'($urandom);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R11: reset state, with a strobe driven during reset.
        in_valid = 1'b1; in_sample = 16'h1234;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        // R6: zero gives the all-ones code.
        send(16'h0000, "R6");
        // R3: bias visible at the smallest magnitudes.
        send(16'h0004, "R3"); send(16'h0003, "R3"); send(16'h0008, "R3");
        send(16'hFFFC, "R3");
        // R2: scaling and the clamp of the most negative value.
        send(16'h8000, "R2"); send(16'h8001, "R2"); send(16'h7FFF, "R2");
        // R1: signs of mirrored values.
        send(16'd1000, "R1"); send(-16'sd1000, "R1"); send(16'hFFFF, "R1");
        // R4: both sides of every segment boundary, both signs.
        for (int p = 5; p <= 12; p++) begin
            int m = (1 << p) - 31;
            send(16'(m * 4), "R4");
            send(16'(m * 4 - 4), "R4");
            send(16'(-(m * 4)), "R4");
        end
        // R5: every step value inside segment 3 (leading one at bit 8).
        for (int s = 0; s < 16; s++) begin
            send(16'(((256 + s * 16) - 31) * 4), "R5");
        end
        // R7: saturation threshold and above.
        send(16'd32644, "R7"); send(16'd32640, "R7"); send(-16'sd32644, "R7");
        // R10: gaps with changing data must not disturb the held code.
        send(16'd5000, "R10");
        idle(4);
        send(-16'sd77, "R10");
        idle(3);
        // R9: back-to-back strobes, then alternating strobes.
        for (int i = 0; i < 20; i++) begin
            send(16'($urandom), "R9");
            if (i % 3 == 0) idle(1);
        end
        // R8: full-range sweep.
        for (int x = -32768; x < 32768; x += 97) begin
            send(16'(x), "R8");
        end
        // R11: reset in the middle of traffic.
        send(16'd300, "R11");
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        idle(3);
        finish_run();
    end
endmodule